// File: doc/BRIEF.md
# One-Hot Frame Sequencer with State Upset Detection

This block sequences the phases of a single frame on a LIN node: the break field, the sync byte, the identifier, a run of data bytes, the checksum byte and a wait for the responder's status reply. An external serializer reports each finished byte, and the sequencer advances on those reports. A receive error sends it to an error state, which falls back to idle on the following cycle.

The state register holds one flip-flop per state, so exactly one bit is set whenever the register is healthy. A monitor looks at the state vector on every cycle. If no bit is set, or more than one bit is set, it raises a sticky fault flag and a one-cycle interrupt. The machine then returns to idle and the frame in progress is dropped. A register write clears the flag. A test input flips one chosen state bit, so that detection and recovery can be exercised without a real upset.

The asynchronous reset is released in step with the clock through a two-stage synchronizer. The block therefore responds to its inputs from the third rising edge after reset is deasserted.

Top module: `frame_seq_onehot`

## Requirements
- R1: After reset, `state_vec` equals 8'h01 (idle), and `fault_flag` and `fault_irq` are 0. State bit positions are: idle 0, break 1, sync 2, identifier 3, data 4, checksum 5, response wait 6, error 7.
- R2: In idle, `frame_start` moves the machine to break. Break, sync and identifier each wait until `tx_byte_done` and then move to sync, identifier and data in that order.
- R3: Data stays put until it has seen `max(1, data_len)` `rx_byte_done` events, then moves to checksum. A `data_len` of 0 acts as 1. Checksum moves to response wait on `rx_byte_done`, and response wait moves to idle on `rx_byte_done`.
- R4: `rx_fault` in any state from break to response wait moves the machine to error on the next edge, and error always returns to idle one cycle later. `rx_fault` has no effect in idle.
- R5: When `state_vec` has zero set bits or two or more set bits, the next edge loads idle (8'h01) and the frame in progress is abandoned.
- R6: `fault_flag` is set on the edge that follows an invalid state vector. It then stays set until `flag_clr`. If a detection and `flag_clr` arrive on the same cycle, the flag stays set.
- R7: `fault_irq` is high for exactly the one cycle after each cycle in which the state vector was invalid.
- R8: While `inj_en` is high, the next edge loads the current state vector with bit `inj_sel` inverted, in place of the normal update.
- R9: As long as `inj_en` stays low, the state vector remains one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts a frame from idle |
| tx_byte_done | input | 1 | Serializer finished sending a header field |
| rx_byte_done | input | 1 | A data, checksum or reply byte was received |
| rx_fault | input | 1 | Receive error reported by the serializer |
| data_len | input | 4 | Number of data bytes in the frame (0 acts as 1) |
| flag_clr | input | 1 | Register write that clears the fault flag |
| inj_en | input | 1 | Flips one state bit on this edge (test) |
| inj_sel | input | 3 | Index of the state bit to flip |
| state_vec | output | 8 | One-hot state vector |
| fault_flag | output | 1 | Sticky flag: invalid state vector detected |
| fault_irq | output | 1 | One-cycle pulse on each detection |

## Verification
The recovery and one-hot properties assume that `inj_en` is never high on a cycle in which the state vector is already invalid. A second flip on that edge would otherwise overwrite the forced return to idle. The stimulus meets this assumption by always injecting from a valid state and leaving the following cycle free of injection. The bench sweeps every frame length from 0 to 8 and a receive error in each active state. It also flips every state bit from every state, all 64 combinations, and checks the flipped vector, the return to idle, the flag and the interrupt pulse for each one.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  localparam int NUM_ST = 8;
  localparam int SEL_W  = $clog2(NUM_ST);
  localparam int LEN_W  = 4;

  localparam int ST_IDLE = 0;
  localparam int ST_BRK  = 1;
  localparam int ST_SYNC = 2;
  localparam int ST_IDENT = 3;
  localparam int ST_DATA = 4;
  localparam int ST_CKS  = 5;
  localparam int ST_RWAIT = 6;
  localparam int ST_ERR  = 7;

  typedef logic [NUM_ST-1:0] st_vec_t;

  localparam st_vec_t IDLE_VEC = st_vec_t'(1) << ST_IDLE;
endpackage

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import frame_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  st_vec_t          nxt_vec,
  input  logic             inj_en,
  input  logic [SEL_W-1:0] inj_sel,
  output st_vec_t          state_q
);
  st_vec_t flip_mask;
  st_vec_t load_vec;

  always_comb begin
    flip_mask = st_vec_t'(1) << inj_sel;
    if (inj_en) load_vec = state_q ^ flip_mask;
    else        load_vec = nxt_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= IDLE_VEC;
    else        state_q <= load_vec;
  end

  // R8
  inj_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |=> state_q == ($past(state_q) ^ (st_vec_t'(1) << $past(inj_sel))));
endmodule

// File: rtl/onehot_monitor.sv
module onehot_monitor
  import frame_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  st_vec_t state_vec,
  input  logic    flag_clr,
  output logic    bad,
  output logic    fault_flag,
  output logic    fault_irq
);
  localparam int CNT_W = $clog2(NUM_ST + 1);

  logic [CNT_W-1:0] ones;
  logic             flag_d;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_ST; i++) ones = ones + CNT_W'(state_vec[i]);
    bad = (ones != CNT_W'(1));
  end

  always_comb begin
    flag_d = fault_flag;
    if (flag_clr) flag_d = 1'b0;
    if (bad)      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_flag <= 1'b0;
      fault_irq  <= 1'b0;
    end else begin
      fault_flag <= flag_d;
      fault_irq  <= bad;
    end
  end

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !flag_clr) |=> fault_flag);
  // R6
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> fault_flag);
  // R7
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !fault_irq);
endmodule

// File: rtl/seq_next_state.sv
module seq_next_state
  import frame_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  st_vec_t state_vec,
  input  logic    bad,
  input  logic    frame_start,
  input  logic    tx_byte_done,
  input  logic    rx_byte_done,
  input  logic    rx_fault,
  input  logic    last_byte,
  output st_vec_t nxt_vec
);
  always_comb begin
    nxt_vec = '0;
    if (bad) begin
      nxt_vec[ST_IDLE] = 1'b1;
    end else if (state_vec[ST_IDLE]) begin
      if (frame_start) nxt_vec[ST_BRK]  = 1'b1;
      else             nxt_vec[ST_IDLE] = 1'b1;
    end else if (state_vec[ST_ERR]) begin
      nxt_vec[ST_IDLE] = 1'b1;
    end else if (rx_fault) begin
      nxt_vec[ST_ERR] = 1'b1;
    end else if (state_vec[ST_BRK]) begin
      if (tx_byte_done) nxt_vec[ST_SYNC] = 1'b1;
      else              nxt_vec[ST_BRK]  = 1'b1;
    end else if (state_vec[ST_SYNC]) begin
      if (tx_byte_done) nxt_vec[ST_IDENT] = 1'b1;
      else              nxt_vec[ST_SYNC]  = 1'b1;
    end else if (state_vec[ST_IDENT]) begin
      if (tx_byte_done) nxt_vec[ST_DATA]  = 1'b1;
      else              nxt_vec[ST_IDENT] = 1'b1;
    end else if (state_vec[ST_DATA]) begin
      if (rx_byte_done && last_byte) nxt_vec[ST_CKS]  = 1'b1;
      else                           nxt_vec[ST_DATA] = 1'b1;
    end else if (state_vec[ST_CKS]) begin
      if (rx_byte_done) nxt_vec[ST_RWAIT] = 1'b1;
      else              nxt_vec[ST_CKS]   = 1'b1;
    end else begin
      if (rx_byte_done) nxt_vec[ST_IDLE]  = 1'b1;
      else              nxt_vec[ST_RWAIT] = 1'b1;
    end
  end

  // R9
  nxt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(nxt_vec));
endmodule

// File: rtl/data_byte_counter.sv
module data_byte_counter
  import frame_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_data,
  input  logic             count_en,
  input  logic [LEN_W-1:0] data_len,
  output logic             last_byte
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_eff;
  logic [LEN_W:0]   seen;

  always_comb begin
    len_eff   = (data_len == '0) ? LEN_W'(1) : data_len;
    seen      = {1'b0, cnt_q} + (LEN_W+1)'(1);
    last_byte = seen >= {1'b0, len_eff};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!in_data) cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + LEN_W'(1);
  end
endmodule

// File: rtl/frame_seq_onehot.sv
module frame_seq_onehot
  import frame_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             tx_byte_done,
  input  logic             rx_byte_done,
  input  logic             rx_fault,
  input  logic [LEN_W-1:0] data_len,
  input  logic             flag_clr,
  input  logic             inj_en,
  input  logic [SEL_W-1:0] inj_sel,
  output logic [NUM_ST-1:0] state_vec,
  output logic             fault_flag,
  output logic             fault_irq
);
  logic    rst_meta_n;
  logic    rst_sync_n;
  st_vec_t nxt_vec;
  st_vec_t state_q;
  logic    bad;
  logic    last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  onehot_monitor i_mon (
    .clk(clk), .rst_n(rst_sync_n), .state_vec(state_q), .flag_clr(flag_clr),
    .bad(bad), .fault_flag(fault_flag), .fault_irq(fault_irq)
  );

  data_byte_counter i_cnt (
    .clk(clk), .rst_n(rst_sync_n), .in_data(state_q[ST_DATA] && !bad),
    .count_en(rx_byte_done), .data_len(data_len), .last_byte(last_byte)
  );

  seq_next_state i_nxt (
    .clk(clk), .rst_n(rst_sync_n), .state_vec(state_q), .bad(bad),
    .frame_start(frame_start), .tx_byte_done(tx_byte_done),
    .rx_byte_done(rx_byte_done), .rx_fault(rx_fault),
    .last_byte(last_byte), .nxt_vec(nxt_vec)
  );

  seq_state_reg i_reg (
    .clk(clk), .rst_n(rst_sync_n), .nxt_vec(nxt_vec), .inj_en(inj_en),
    .inj_sel(inj_sel), .state_q(state_q)
  );

  assign state_vec = state_q;

  // R5
  bad_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bad && !inj_en) |=> state_vec == IDLE_VEC);
  // R4
  err_exit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_vec[ST_ERR] && !inj_en) |=> state_vec == IDLE_VEC);
endmodule

// File: tb/test_frame_seq_onehot.sv
module test_frame_seq_onehot;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start, tx_byte_done, rx_byte_done, rx_fault;
  logic [3:0] data_len;
  logic       flag_clr, inj_en;
  logic [2:0] inj_sel;
  logic [7:0] state_vec;
  logic       fault_flag, fault_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq_onehot i_frame_seq_onehot (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .tx_byte_done(tx_byte_done), .rx_byte_done(rx_byte_done),
    .rx_fault(rx_fault), .data_len(data_len), .flag_clr(flag_clr),
    .inj_en(inj_en), .inj_sel(inj_sel), .state_vec(state_vec),
    .fault_flag(fault_flag), .fault_irq(fault_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives the given inputs for exactly one rising edge, returns at a falling edge
  task automatic cyc(input logic s, t, r, e, c, i, input logic [2:0] sel);
    frame_start = s; tx_byte_done = t; rx_byte_done = r; rx_fault = e;
    flag_clr = c; inj_en = i; inj_sel = sel;
    @(negedge clk);
    frame_start = 0; tx_byte_done = 0; rx_byte_done = 0; rx_fault = 0;
    flag_clr = 0; inj_en = 0; inj_sel = 0;
  endtask

  task automatic idle_cyc();
    cyc(0, 0, 0, 0, 0, 0, 3'd0);
  endtask

  // from idle, with data_len = 2, walk to state k
  task automatic advance_to(input int k);
    if (k == 7) begin
      cyc(1, 0, 0, 0, 0, 0, 3'd0);
      cyc(0, 0, 0, 1, 0, 0, 3'd0);
    end else begin
      if (k >= 1) cyc(1, 0, 0, 0, 0, 0, 3'd0);
      if (k >= 2) cyc(0, 1, 0, 0, 0, 0, 3'd0);
      if (k >= 3) cyc(0, 1, 0, 0, 0, 0, 3'd0);
      if (k >= 4) cyc(0, 1, 0, 0, 0, 0, 3'd0);
      if (k >= 5) begin
        cyc(0, 0, 1, 0, 0, 0, 3'd0);
        cyc(0, 0, 1, 0, 0, 0, 3'd0);
      end
      if (k >= 6) cyc(0, 0, 1, 0, 0, 0, 3'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    frame_start = 0; tx_byte_done = 0; rx_byte_done = 0; rx_fault = 0;
    flag_clr = 0; inj_en = 0; inj_sel = 0; data_len = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 state", state_vec, 8'h01);
    check("R1 flag", {7'b0, fault_flag}, 8'h00);
    check("R1 irq", {7'b0, fault_irq}, 8'h00);

    // R2 / R3: sweep frame lengths
    for (int n = 0; n <= 8; n++) begin
      int n_eff;
      n_eff = (n == 0) ? 1 : n;
      data_len = 4'(n);
      idle_cyc();
      check("R2 idle hold", state_vec, 8'h01);
      cyc(1, 0, 0, 0, 0, 0, 3'd0);
      check("R2 break", state_vec, 8'h02);
      idle_cyc();
      check("R2 break waits", state_vec, 8'h02);
      cyc(0, 1, 0, 0, 0, 0, 3'd0);
      check("R2 sync", state_vec, 8'h04);
      cyc(0, 1, 0, 0, 0, 0, 3'd0);
      check("R2 ident", state_vec, 8'h08);
      cyc(0, 1, 0, 0, 0, 0, 3'd0);
      check("R2 data", state_vec, 8'h10);
      for (int b = 1; b < n_eff; b++) begin
        cyc(0, 0, 1, 0, 0, 0, 3'd0);
        check("R3 data stays", state_vec, 8'h10);
      end
      cyc(0, 0, 1, 0, 0, 0, 3'd0);
      check("R3 checksum", state_vec, 8'h20);
      cyc(0, 0, 1, 0, 0, 0, 3'd0);
      check("R3 rwait", state_vec, 8'h40);
      cyc(0, 0, 1, 0, 0, 0, 3'd0);
      check("R3 back idle", state_vec, 8'h01);
      check("R9 no flag", {7'b0, fault_flag}, 8'h00);
    end

    // R4 receive error from each active state
    data_len = 4'd2;
    cyc(0, 0, 0, 1, 0, 0, 3'd0);
    check("R4 ignored in idle", state_vec, 8'h01);
    for (int k = 1; k <= 6; k++) begin
      advance_to(k);
      check("R4 reached", state_vec, 8'(1 << k));
      cyc(0, 0, 0, 1, 0, 0, 3'd0);
      check("R4 error", state_vec, 8'h80);
      idle_cyc();
      check("R4 error exit", state_vec, 8'h01);
    end

    // R5..R8 flip every bit from every state
    for (int k = 0; k <= 7; k++) begin
      for (int s = 0; s <= 7; s++) begin
        logic [7:0] cur;
        advance_to(k);
        cur = 8'(1 << k);
        check("R8 start state", state_vec, cur);
        cyc(0, 0, 0, 0, 0, 1, 3'(s));
        check("R8 flipped", state_vec, cur ^ 8'(1 << s));
        check("R6 not yet", {7'b0, fault_flag}, 8'h00);
        idle_cyc();
        check("R5 recovered", state_vec, 8'h01);
        check("R6 flag set", {7'b0, fault_flag}, 8'h01);
        check("R7 irq pulse", {7'b0, fault_irq}, 8'h01);
        idle_cyc();
        check("R7 irq ends", {7'b0, fault_irq}, 8'h00);
        check("R6 sticky", {7'b0, fault_flag}, 8'h01);
        cyc(0, 0, 0, 0, 1, 0, 3'd0);
        check("R6 cleared", {7'b0, fault_flag}, 8'h00);
      end
    end

    // R6 set wins over clear
    advance_to(2);
    cyc(0, 0, 0, 0, 0, 1, 3'd5);
    cyc(0, 0, 0, 0, 1, 0, 3'd0);
    check("R6 set beats clear", {7'b0, fault_flag}, 8'h01);
    check("R5 idle after", state_vec, 8'h01);
    cyc(0, 0, 0, 0, 1, 0, 3'd0);
    check("R6 final clear", {7'b0, fault_flag}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule